// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block is a register-mapped master for the IEEE 802.3 Clause 45 management interface. Software packs a whole management frame into one 32-bit word. The word holds the start code, the opcode, the port address, the device address, the turnaround code and a 16-bit address or data payload. Software then toggles a launch bit in a control word and polls a busy flag. The block drives the management clock from the system clock through a parameterized divider. It sends 32 preamble ones and then the 32 frame bits, most significant bit first. On a read it lets go of the data line for the turnaround and payload periods.

When a read ends, the 16 bits returned by the PHY overwrite the payload half of the frame word. The upper half of the word is left unchanged, so software fetches the result from the same location it wrote. Address-then-data sequencing is left to software: it issues an address frame, then a write or read frame.

Top module: `mdio_c45_master`

## Requirements
- R1: Register word offsets: control at 0x10, frame at 0x11, status at 0x14 (busy in bit 0). Control and frame read back the last value written. Any other offset reads 0. All registers are 0 after reset.
- R2: A write to the control word that changes bit 3 from 0 to 1 while idle starts a frame. The status busy bit reads 1 from the next cycle.
- R3: A 0-to-1 change of control bit 3 while busy is ignored. The current frame still has exactly 64 clock periods, and no further frame follows it.
- R4: A frame spans 64 management clock periods. The first 32 carry ones, and the next 32 carry frame bits 31 down to 0.
- R5: MDC stays low for DIV/2 system cycles in each period. It is high whenever no frame is active.
- R6: The master changes its data output only while MDC is low, just after the falling edge. It samples the incoming line at the rising edge.
- R7: When frame bits 29:28 are 11 (read), the output enable is low for the last 18 periods (turnaround and payload). For opcodes 00 (address) and 01 (write), the output enable is high for all 64 periods.
- R8: At the end of a read, the 16 bits sampled in the last 16 periods are placed into frame bits 15:0, first-received bit in bit 15. Bits 31:16 keep their value, and the frame word is unchanged after a non-read frame.
- R9: Busy clears when the frame ends. From then on MDC is high and the output enable is low until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock to PHYs |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable (high drives the line) |
| mdio_i | input | 1 | Data line input value |

## Verification
The assertions take for granted that DIV is even and at least 4, so that a falling and a rising strobe never fall in the same cycle. They also take for granted that the PHY holds the data line steady around each rising MDC edge. The stimulus meets these conditions in three ways. It keeps the default divider. Its PHY model changes the line only on falling MDC edges. It builds frames only with start code 00, turnaround 10 and the opcodes 00, 01 and 11. Random port, device and payload values are mixed with directed frames, which cover all-zero and all-one read data and a start edge issued in the middle of a busy frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int          REG_AW     = 5;
    localparam logic [4:0]  OFS_CTRL   = 5'h10;
    localparam logic [4:0]  OFS_FRAME  = 5'h11;
    localparam logic [4:0]  OFS_STAT   = 5'h14;
    localparam int          LAUNCH_BIT = 3;

    localparam int PRE_LEN     = 32;
    localparam int FRAME_LEN   = 32;
    localparam int PAYLOAD_LEN = 16;
    localparam int TA_LEN      = 2;
    localparam int TOTAL       = PRE_LEN + FRAME_LEN;
    // first period in which a read releases the line (turnaround)
    localparam int RELEASE_AT  = TOTAL - PAYLOAD_LEN - TA_LEN;
    // first period that carries read data
    localparam int DATA_AT     = TOTAL - PAYLOAD_LEN;

    typedef enum logic [1:0] {
        OP_ADDR  = 2'b00,
        OP_WRITE = 2'b01,
        OP_RSVD  = 2'b10,
        OP_READ  = 2'b11
    } mdio_op_e;

    typedef struct packed {
        logic [1:0]             st;
        mdio_op_e               op;
        logic [4:0]             port;
        logic [4:0]             dev;
        logic [1:0]             ta;
        logic [PAYLOAD_LEN-1:0] payload;
    } frame_t;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_RUN  = 1'b1
    } eng_state_e;

    function automatic logic frame_is_read(input frame_t f);
        return f.op == OP_READ;
    endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic halt,
    output logic mdc,
    output logic fall_stb,
    output logic rise_stb
);
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int HALF = DIV / 2;

    logic [CW-1:0] cnt;

    assign fall_stb = en && (cnt == '0);
    assign rise_stb = en && (cnt == CW'(HALF));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
            mdc <= 1'b1;
        end else begin
            cnt <= (cnt == CW'(DIV - 1)) ? '0 : cnt + 1'b1;
            if (fall_stb && !halt)
                mdc <= 1'b0;
            else if (rise_stb)
                mdc <= 1'b1;
        end
    end

    // R5
    mdc_idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> mdc);

    // R5
    mdc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !fall_stb && !rise_stb) |=> $stable(mdc));

endmodule

// File: rtl/mdio_shift_engine.sv
module mdio_shift_engine
    import mdio_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  frame_t                 frame,
    input  logic                   fall_stb,
    input  logic                   rise_stb,
    input  logic                   mdio_i,
    output logic                   busy,
    output logic                   halt,
    output logic                   mdio_o,
    output logic                   mdio_oe,
    output logic                   rd_valid,
    output logic [PAYLOAD_LEN-1:0] rd_payload
);
    localparam int CW = $clog2(TOTAL + 1);

    eng_state_e             state;
    logic [TOTAL-1:0]       sreg;
    logic [CW-1:0]          bit_idx;
    logic                   rd_op;
    logic                   done;
    logic [PAYLOAD_LEN-1:0] cap;

    assign halt       = (state == ENG_RUN) && (bit_idx == CW'(TOTAL));
    assign busy       = (state == ENG_RUN) || done;
    assign rd_valid   = done && rd_op;
    assign rd_payload = cap;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ENG_IDLE;
            sreg    <= '0;
            bit_idx <= '0;
            rd_op   <= 1'b0;
            done    <= 1'b0;
            cap     <= '0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ENG_IDLE: begin
                    if (start && !done) begin
                        state   <= ENG_RUN;
                        sreg    <= {{PRE_LEN{1'b1}}, frame};
                        bit_idx <= '0;
                        rd_op   <= frame_is_read(frame);
                        cap     <= '0;
                    end
                end
                ENG_RUN: begin
                    if (fall_stb) begin
                        if (halt) begin
                            state   <= ENG_IDLE;
                            mdio_oe <= 1'b0;
                            done    <= 1'b1;
                        end else begin
                            mdio_o  <= sreg[TOTAL-1];
                            sreg    <= sreg << 1;
                            mdio_oe <= !(rd_op && (bit_idx >= CW'(RELEASE_AT)));
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                    if (rise_stb && rd_op && (bit_idx > CW'(DATA_AT)))
                        cap <= {cap[PAYLOAD_LEN-2:0], mdio_i};
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    // R4
    period_bound_chk: assert property (@(posedge clk) disable iff (rst)
        bit_idx <= CW'(TOTAL));

    // R7
    read_release_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ENG_RUN && rd_op && bit_idx > CW'(RELEASE_AT)) |-> !mdio_oe);

    // R9
    idle_released_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdio_oe);

endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
    import mdio_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   reg_wr,
    input  logic [REG_AW-1:0]      reg_addr,
    input  logic [31:0]            reg_wdata,
    input  logic                   busy,
    input  logic                   rd_valid,
    input  logic [PAYLOAD_LEN-1:0] rd_payload,
    output logic [31:0]            frame_word,
    output logic                   start,
    output logic [31:0]            reg_rdata
);
    logic [31:0] ctrl_q;
    logic [31:0] frame_q;

    assign frame_word = frame_q;
    assign start = reg_wr && (reg_addr == OFS_CTRL)
                   && reg_wdata[LAUNCH_BIT] && !ctrl_q[LAUNCH_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            frame_q <= '0;
        end else begin
            if (reg_wr && reg_addr == OFS_CTRL)
                ctrl_q <= reg_wdata;
            if (rd_valid)
                frame_q[PAYLOAD_LEN-1:0] <= rd_payload;
            else if (reg_wr && reg_addr == OFS_FRAME)
                frame_q <= reg_wdata;
        end
    end

    always_comb begin
        case (reg_addr)
            OFS_CTRL:  reg_rdata = ctrl_q;
            OFS_FRAME: reg_rdata = frame_q;
            OFS_STAT:  reg_rdata = {31'd0, busy};
            default:   reg_rdata = '0;
        endcase
    end

    // R8
    upper_kept_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> frame_q[31:PAYLOAD_LEN] == $past(frame_q[31:PAYLOAD_LEN]));

endmodule

// File: rtl/mdio_c45_master.sv
module mdio_c45_master
    import mdio_pkg::*;
#(
    parameter int DIV = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [4:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic                   busy;
    logic                   halt;
    logic                   start;
    logic                   fall_stb;
    logic                   rise_stb;
    logic                   rd_valid;
    logic [PAYLOAD_LEN-1:0] rd_payload;
    logic [31:0]            frame_word;
    frame_t                 frame;

    assign frame = frame_t'(frame_word);

    mdio_regfile u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .busy       (busy),
        .rd_valid   (rd_valid),
        .rd_payload (rd_payload),
        .frame_word (frame_word),
        .start      (start),
        .reg_rdata  (reg_rdata)
    );

    mdio_clk_div #(.DIV(DIV)) u_div (
        .clk      (clk),
        .rst      (rst),
        .en       (busy),
        .halt     (halt),
        .mdc      (mdc),
        .fall_stb (fall_stb),
        .rise_stb (rise_stb)
    );

    mdio_shift_engine u_eng (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .frame      (frame),
        .fall_stb   (fall_stb),
        .rise_stb   (rise_stb),
        .mdio_i     (mdio_i),
        .busy       (busy),
        .halt       (halt),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .rd_valid   (rd_valid),
        .rd_payload (rd_payload)
    );

    // R6
    data_change_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(mdio_o) |-> !mdc);

    // R9
    end_mdc_high_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> mdc);

endmodule

// File: tb/mdio_c45_master_test.sv
module mdio_c45_master_test;

    localparam int DIV    = 8;
    localparam int LOW_NS = (DIV / 2) * 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [4:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i;

    int vectors = 0;
    int miscompares = 0;

    always #5 clk = ~clk;

    mdio_c45_master #(.DIV(DIV)) uut (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    // PHY model and line monitor
    int          idx;
    int          bad_low;
    int          bad_change;
    logic [63:0] obits;
    logic [63:0] ooe;
    logic        phy_read;
    logic [15:0] phy_data;
    realtime     t_fall;
    logic        o_at_fall;

    initial begin
        mdio_i   = 1'b1;
        phy_read = 1'b0;
        phy_data = '0;
        t_fall   = 0;
        idx      = 0;
        o_at_fall = 1'b1;
    end

    always @(negedge mdc) begin
        t_fall    = $realtime;
        o_at_fall = mdio_o;
        if (phy_read && idx >= 48 && idx < 64)
            mdio_i = phy_data[63 - idx];
        else
            mdio_i = 1'b1;
    end

    always @(posedge mdc) begin
        if (idx < 64) begin
            if ($realtime - t_fall != LOW_NS) bad_low++;
            if (mdio_o !== o_at_fall) bad_change++;
            obits[63 - idx] = mdio_o;
            ooe[63 - idx]   = mdio_oe;
        end
        idx++;
    end

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] mk_frame(input logic [1:0] op, input logic [4:0] port,
                                             input logic [4:0] dev, input logic [15:0] pl);
        return {2'b00, op, port, dev, 2'b10, pl};
    endfunction

    task automatic run_frame(input logic [31:0] f, input logic [15:0] pd, input bit mid_start);
        logic [31:0] v;
        logic [63:0] exp_bits;
        logic [31:0] exp_frame;
        bit          is_rd;
        int          guard;
        is_rd      = (f[29:28] == 2'b11);
        idx        = 0;
        bad_low    = 0;
        bad_change = 0;
        phy_read   = is_rd;
        phy_data   = pd;
        wr(5'h11, f);
        wr(5'h10, 32'h5);
        wr(5'h10, 32'hD);
        wr(5'h10, 32'h5);
        rd(5'h14, v);
        chk(v[0] == 1'b1, "R2 busy after launch", 64'(v), 64'd1);
        if (mid_start) begin
            repeat (100) @(negedge clk);
            wr(5'h10, 32'hD);
            wr(5'h10, 32'h5);
        end
        guard = 0;
        do begin
            rd(5'h14, v);
            guard++;
        end while (v[0] && guard < 5000);
        chk(idx == 64, "R4 period count", 64'(idx), 64'd64);
        chk(bad_low == 0, "R5 mdc low width", 64'(bad_low), 64'd0);
        chk(bad_change == 0, "R6 data steady from fall to rise", 64'(bad_change), 64'd0);
        chk(mdc === 1'b1 && mdio_oe === 1'b0, "R9 idle after frame",
            64'({mdc, mdio_oe}), 64'b10);
        exp_bits = {32'hFFFF_FFFF, f};
        if (is_rd) begin
            chk(obits[63:18] === exp_bits[63:18], "R4 driven bits of read",
                64'(obits[63:18]), 64'(exp_bits[63:18]));
            chk(ooe === {{46{1'b1}}, 18'd0}, "R7 read release window",
                ooe, {{46{1'b1}}, 18'd0});
            exp_frame = {f[31:16], pd};
        end else begin
            chk(obits === exp_bits, "R4 serialized bits", obits, exp_bits);
            chk(ooe === {64{1'b1}}, "R7 drive enable", ooe, {64{1'b1}});
            exp_frame = f;
        end
        rd(5'h11, v);
        chk(v === exp_frame, "R8 frame word after completion", 64'(v), 64'(exp_frame));
        if (mid_start) begin
            repeat (3 * DIV) @(negedge clk);
            rd(5'h14, v);
            chk(v[0] == 1'b0 && idx == 64, "R3 start while busy ignored",
                64'({v[0], 7'(idx)}), 64'(8'd64));
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        miscompares++;
        vectors++;
        $display("FAIL watchdog R9 busy never cleared actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        logic [31:0] seed;
        rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        seed = $urandom(32'h5EED_0045);
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // reset state (R1, R9)
        rd(5'h10, v); chk(v === 32'd0, "R1 control reset", 64'(v), 64'd0);
        rd(5'h11, v); chk(v === 32'd0, "R1 frame reset", 64'(v), 64'd0);
        rd(5'h14, v); chk(v === 32'd0, "R1 status reset", 64'(v), 64'd0);
        chk(mdc === 1'b1 && mdio_oe === 1'b0, "R9 idle lines after reset",
            64'({mdc, mdio_oe}), 64'b10);

        // R1 read-back and unmapped offset
        wr(5'h11, 32'h1234_ABCD);
        rd(5'h11, v); chk(v === 32'h1234_ABCD, "R1 frame read-back", 64'(v), 64'h1234ABCD);
        wr(5'h10, 32'h5);
        rd(5'h10, v); chk(v === 32'h5, "R1 control read-back", 64'(v), 64'h5);
        rd(5'h12, v); chk(v === 32'd0, "R1 unmapped offset", 64'(v), 64'd0);
        rd(5'h14, v); chk(v[0] === 1'b0, "R2 no launch without rising bit", 64'(v), 64'd0);

        // directed frames
        run_frame(mk_frame(2'b00, 5'h03, 5'h05, 16'hA5C3), 16'h0000, 1'b0);
        run_frame(mk_frame(2'b01, 5'h1F, 5'h1F, 16'hFFFF), 16'h0000, 1'b0);
        run_frame(mk_frame(2'b11, 5'h00, 5'h05, 16'h0000), 16'h8001, 1'b0);
        run_frame(mk_frame(2'b11, 5'h11, 5'h01, 16'h5A5A), 16'hFFFF, 1'b0);
        run_frame(mk_frame(2'b11, 5'h0A, 5'h07, 16'hFFFF), 16'h0000, 1'b0);
        run_frame(mk_frame(2'b01, 5'h04, 5'h02, 16'h0F0F), 16'h0000, 1'b1);
        run_frame(mk_frame(2'b11, 5'h15, 5'h05, 16'h1357), 16'hC3A5, 1'b1);

        // constrained random frames
        for (int i = 0; i < 12; i++) begin
            logic [1:0] op;
            case ($urandom_range(2))
                0:       op = 2'b00;
                1:       op = 2'b01;
                default: op = 2'b11;
            endcase
            run_frame(mk_frame(op, 5'($urandom), 5'($urandom), 16'($urandom)),
                      16'($urandom), 1'b0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule